// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM array alive. A free-running interval timer adds one owed refresh to a backlog every refresh slot. The slot is the 64 ms retention window shared across 4096 rows, converted to clock cycles and rounded down. While anything is owed, the block raises a request to the command arbiter. Once the arbiter grants the bus, the block owns the command pins until its request drops.

If any bank is still open when the grant arrives, the block first issues a precharge of every bank and waits out the precharge time. It then issues an auto-refresh and keeps the pins quiet for the refresh cycle time. The device walks its own row counter, so the block drives no row address. Up to eight refreshes may be postponed; at that depth an urgent flag tells the arbiter to stop deferring.

A low-power request takes the same route, but it ends in self-refresh. The refresh pin pattern is issued with the clock enable dropped in the same cycle. The clock enable stays low while the request is held. When the request is released, the clock enable is raised and the pins stay quiet for a refresh cycle time before the bus is given back.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and straight after reset, cke is high, the command pins are deselect (cs_n, ras_n, cas_n, we_n all 1), ap is low, and ref_req and ref_urgent are low.
- R2: The backlog grows by one every INTERVAL = CLK_KHZ*WINDOW_MS/ROWS clock cycles, counted from reset release. ref_req is high whenever the backlog is non-zero: it is first seen high exactly INTERVAL cycles after release and low one cycle earlier.
- R3: ref_urgent rises exactly when the backlog reaches MAX_PEND (8). The backlog saturates there, so after longer neglect exactly MAX_PEND refreshes are served. ref_urgent never appears without ref_req.
- R4: When grant is sampled high in idle with a non-zero backlog and bank_open all zero, the next cycle carries an auto-refresh: cs_n=0, ras_n=0, cas_n=0, we_n=1, with cke high. Each auto-refresh removes one from the backlog, so after draining, the refreshes issued equal the elapsed intervals.
- R5: If any bank_open bit is set at that grant, the next cycle carries a precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, ap=1). The refresh follows exactly T_RP_CLK cycles later, with only NOPs (cs_n=0, ras_n, cas_n and we_n all 1) between. Refresh is only issued with every bank closed.
- R6: For the T_RFC_CLK cycles after any refresh pattern, the pins carry no command. ref_req stays high through cycle T_RFC_CLK-1 and drops at cycle T_RFC_CLK when the backlog is empty.
- R7: With no grant, no command leaves the block. A grant received while nothing is owed and no low-power request is pending is ignored.
- R8: On a grant with lp_req high, the refresh pattern is issued with cke going low in that same cycle, and the backlog is cleared.
- R9: While in self-refresh, cke stays low, cs_n stays high, ref_req stays high, and the interval timer is held, so no backlog builds up.
- R10: One cycle after lp_req falls, cke is high with no command on the pins. ref_req stays high through cycle T_RFC_CLK-1 and drops at cycle T_RFC_CLK.
- R11: When lp_req and a non-zero backlog are both present at a grant, self-refresh entry is taken instead of auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req | input | 1 | Low-power request: enter self-refresh while high |
| grant | input | 1 | Arbiter grant, acted on only while the block is idle |
| bank_open | input | NBANK | One bit per bank that currently holds an open row |
| ref_req | output | 1 | Bus request; high while refresh is owed, low-power is requested, or the block is busy |
| ref_urgent | output | 1 | Backlog has reached MAX_PEND |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ap | output | 1 | All-bank select bit for precharge (address bit 10) |

## Verification
A grant sampled at one rising edge shows up as a precharge or refresh one cycle later. A refresh follows its precharge T_RP_CLK cycles after that. The request drops T_RFC_CLK cycles after a refresh or after the self-refresh exit edge, and the backlog and its urgent flag change on exactly the INTERVAL-th edge after release. The bench counts rising edges from reset release, moves inputs and samples outputs on the falling edge, and compares each output after exactly the number of edges these latencies predict. It also checks the edge one cycle earlier where a boundary matters. A falling-edge monitor measures the distance from every precharge and refresh to the next command, and the randomized phase ends by checking the number of refreshes against the elapsed intervals.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

    // Command pin bundle, active-low, in the order the device decodes it
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_pins_t;

    localparam sdr_pins_t PINS_DESEL   = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_pins_t PINS_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_pins_t PINS_PRECHG  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_pins_t PINS_AUTOREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE_WAIT,
        SQ_RFC_WAIT,
        SQ_SELF,
        SQ_SELF_EXIT
    } seq_state_e;

    // Bits needed to hold values 0..maxval
    function automatic int unsigned cnt_bits(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int unsigned CW = cnt_bits(INTERVAL - 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    // One slot boundary per INTERVAL cycles while running
    assign tick = !hold && (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (hold) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic pending,
    output logic urgent
);
    localparam int unsigned PW = cnt_bits(MAX_PEND);
    localparam logic [PW-1:0] FULL = PW'(MAX_PEND);

    typedef struct packed {
        logic [PW-1:0] owed;
    } blog_t;

    blog_t blog_d, blog_q;

    assign pending = (blog_q.owed != '0);
    assign urgent  = (blog_q.owed == FULL);

    always_comb begin
        blog_d = blog_q;
        if (clr) begin
            blog_d.owed = '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (blog_q.owed != FULL) blog_d.owed = blog_q.owed + 1'b1;
                2'b01: if (blog_q.owed != '0)   blog_d.owed = blog_q.owed - 1'b1;
                default: blog_d.owed = blog_q.owed;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blog_q <= '0;
        end else begin
            blog_q <= blog_d;
        end
    end

endmodule

// File: rtl/sdram_ref_seq.sv
module sdram_ref_seq
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned T_RP_CLK  = 2,
    parameter int unsigned T_RFC_CLK = 4,
    parameter int unsigned NBANK     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             lp_req,
    input  logic [NBANK-1:0] bank_open,
    input  logic             pending,
    output sdr_pins_t        pins,
    output logic             ap,
    output logic             cke,
    output logic             busy,
    output logic             issue_ref,
    output logic             enter_self,
    output logic             self_hold
);
    localparam int unsigned WW = cnt_bits(max2(T_RP_CLK, T_RFC_CLK));
    localparam logic [WW-1:0] RP_LOAD  = WW'(T_RP_CLK - 1);
    localparam logic [WW-1:0] RFC_LOAD = WW'(T_RFC_CLK - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [WW-1:0] wait_cnt;
        logic          goal_self;
        sdr_pins_t     pins;
        logic          ap;
        logic          cke;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fire_ref;

    assign pins      = seq_q.pins;
    assign ap        = seq_q.ap;
    assign cke       = seq_q.cke;
    assign busy      = (seq_q.st != SQ_IDLE);
    assign self_hold = (seq_q.st == SQ_SELF) || (seq_q.st == SQ_SELF_EXIT);

    always_comb begin
        seq_d      = seq_q;
        seq_d.pins = PINS_NOP;
        seq_d.ap   = 1'b0;
        fire_ref   = 1'b0;
        issue_ref  = 1'b0;
        enter_self = 1'b0;

        unique case (seq_q.st)
            SQ_IDLE: begin
                if (grant && (lp_req || pending)) begin
                    seq_d.goal_self = lp_req;
                    if (|bank_open) begin
                        seq_d.pins     = PINS_PRECHG;
                        seq_d.ap       = 1'b1;
                        seq_d.st       = SQ_PRE_WAIT;
                        seq_d.wait_cnt = RP_LOAD;
                    end else begin
                        fire_ref = 1'b1;
                    end
                end
            end
            SQ_PRE_WAIT: begin
                if (seq_q.wait_cnt == '0) begin
                    fire_ref = 1'b1;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
                end
            end
            SQ_RFC_WAIT: begin
                if (seq_q.wait_cnt == '0) begin
                    seq_d.st = SQ_IDLE;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
                end
            end
            SQ_SELF: begin
                seq_d.pins = PINS_DESEL;
                if (!lp_req) begin
                    seq_d.pins     = PINS_NOP;
                    seq_d.cke      = 1'b1;
                    seq_d.st       = SQ_SELF_EXIT;
                    seq_d.wait_cnt = RFC_LOAD;
                end
            end
            SQ_SELF_EXIT: begin
                if (seq_q.wait_cnt == '0) begin
                    seq_d.st = SQ_IDLE;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
                end
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase

        // Shared refresh launch: auto-refresh or self-refresh entry
        if (fire_ref) begin
            seq_d.pins = PINS_AUTOREF;
            if (seq_d.goal_self) begin
                seq_d.cke  = 1'b0;
                seq_d.st   = SQ_SELF;
                enter_self = 1'b1;
            end else begin
                seq_d.st       = SQ_RFC_WAIT;
                seq_d.wait_cnt = RFC_LOAD;
                issue_ref      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st        <= SQ_IDLE;
            seq_q.wait_cnt  <= '0;
            seq_q.goal_self <= 1'b0;
            seq_q.pins      <= PINS_DESEL;
            seq_q.ap        <= 1'b0;
            seq_q.cke       <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 50000,
    parameter int unsigned WINDOW_MS = 64,
    parameter int unsigned ROWS      = 4096,
    parameter int unsigned T_RP_CLK  = 2,
    parameter int unsigned T_RFC_CLK = 4,
    parameter int unsigned MAX_PEND  = 8,
    parameter int unsigned NBANK     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_req,
    input  logic             grant,
    input  logic [NBANK-1:0] bank_open,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             ap
);
    // Refresh slot in clocks, rounded down
    localparam int unsigned INTERVAL = (CLK_KHZ * WINDOW_MS) / ROWS;

    logic      slot_tick;
    logic      owed;
    logic      busy;
    logic      issue_ref;
    logic      enter_self;
    logic      self_hold;
    sdr_pins_t pins;

    sdram_ref_interval #(
        .INTERVAL (INTERVAL)
    ) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (self_hold),
        .tick  (slot_tick)
    );

    sdram_ref_backlog #(
        .MAX_PEND (MAX_PEND)
    ) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (slot_tick),
        .dec     (issue_ref),
        .clr     (enter_self),
        .pending (owed),
        .urgent  (ref_urgent)
    );

    sdram_ref_seq #(
        .T_RP_CLK  (T_RP_CLK),
        .T_RFC_CLK (T_RFC_CLK),
        .NBANK     (NBANK)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .lp_req     (lp_req),
        .bank_open  (bank_open),
        .pending    (owed),
        .pins       (pins),
        .ap         (ap),
        .cke        (cke),
        .busy       (busy),
        .issue_ref  (issue_ref),
        .enter_self (enter_self),
        .self_hold  (self_hold)
    );

    assign ref_req = busy || owed || lp_req;
    assign cs_n    = pins.cs_n;
    assign ras_n   = pins.ras_n;
    assign cas_n   = pins.cas_n;
    assign we_n    = pins.we_n;

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
    parameter int unsigned T_RP_CLK  = 2,
    parameter int unsigned T_RFC_CLK = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ref_req,
    input logic ref_urgent,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ap
);
    localparam int unsigned CW = (T_RP_CLK > T_RFC_CLK) ? $clog2(T_RP_CLK + 2) : $clog2(T_RFC_CLK + 2);
    localparam logic [CW-1:0] RP_SAT  = CW'(T_RP_CLK);
    localparam logic [CW-1:0] RP_LAST = CW'(T_RP_CLK - 1);
    localparam logic [CW-1:0] RFC_SAT = CW'(T_RFC_CLK);

    logic is_ref, is_pre, quiet;
    logic [CW-1:0] since_pre_q, since_ref_q;

    assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
    assign quiet  = cs_n || (ras_n && cas_n && we_n);

    // Distance counters: value k means the sampled cycle is k+1 after the event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q <= RP_SAT;
            since_ref_q <= RFC_SAT;
        end else begin
            if (is_pre)                 since_pre_q <= '0;
            else if (since_pre_q < RP_SAT) since_pre_q <= since_pre_q + 1'b1;
            if (is_ref)                  since_ref_q <= '0;
            else if (since_ref_q < RFC_SAT) since_ref_q <= since_ref_q + 1'b1;
        end
    end

    p_ap_on_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> ap);

    p_pre_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_pre_q < RP_LAST) |-> quiet);

    p_pre_to_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_pre_q == RP_LAST) |-> is_ref);

    p_rfc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ref_q < RFC_SAT) |-> quiet);

    p_urgent_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    p_cke_fall_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> is_ref);

    p_self_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$fell(cke)) |-> cs_n);

    p_self_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> ref_req);

    p_cke_rise_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> quiet);

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
    .T_RP_CLK  (T_RP_CLK),
    .T_RFC_CLK (T_RFC_CLK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ap         (ap)
);

// File: tb/tb_sdram_refresh_sched.sv
module tb_sdram_refresh_sched;
    localparam int CLK_KHZ  = 50000;
    localparam int T_RP     = 2;
    localparam int T_RFC    = 4;
    localparam int MAX_PEND = 8;
    localparam int NB       = 4;
    localparam int N        = (CLK_KHZ * 64) / 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lp_req = 1'b0;
    logic          grant = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic ref_req, ref_urgent, cke, cs_n, ras_n, cas_n, we_n, ap;

    int  checks = 0;
    int  fails = 0;
    int  refs_seen = 0;
    int  edges = 0;
    int  m_after_ref = 1000;
    int  m_after_pre = 1000;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    sdram_refresh_sched #(
        .CLK_KHZ   (CLK_KHZ),
        .T_RP_CLK  (T_RP),
        .T_RFC_CLK (T_RFC),
        .MAX_PEND  (MAX_PEND),
        .NBANK     (NB)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_req     (lp_req),
        .grant      (grant),
        .bank_open  (bank_open),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ap         (ap)
    );

    always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

    function automatic bit f_ref();
        return !cs_n && !ras_n && !cas_n && we_n;
    endfunction
    function automatic bit f_pre();
        return !cs_n && !ras_n && cas_n && !we_n;
    endfunction
    function automatic bit f_quiet();
        return cs_n || (ras_n && cas_n && we_n);
    endfunction
    function automatic int exp_refs(input int e);
        return e / N;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", rq, act, exp, $time);
        end
    endtask

    // Command spacing monitor (R5, R6)
    always @(negedge clk) begin
        if (!rst_n) begin
            m_after_ref = 1000;
            m_after_pre = 1000;
        end else if (!done) begin
            if (m_after_ref < 1000) m_after_ref++;
            if (m_after_pre < 1000) m_after_pre++;
            if (m_after_pre == T_RP)     chk(f_ref(), "R5 refresh after precharge", int'(f_ref()), 1);
            else if (m_after_pre < T_RP) chk(f_quiet(), "R5 quiet after precharge", int'(f_quiet()), 1);
            if (m_after_ref <= T_RFC)    chk(f_quiet(), "R6 quiet after refresh", int'(f_quiet()), 1);
            if (f_ref()) begin
                m_after_ref = 0;
                if (cke) refs_seen++;
                chk(bank_open == '0, "R5 banks closed at refresh", int'(bank_open), 0);
            end
            if (f_pre()) begin
                m_after_pre = 0;
                chk(ap, "R5 precharge-all bit", int'(ap), 1);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; grant = 1'b0; lp_req = 1'b0; bank_open = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        int guard = 0;
        grant = 1'b1;
        while (ref_req && guard < 500) begin
            @(negedge clk);
            if (f_pre()) bank_open = '0;
            guard++;
        end
        grant = 1'b0;
        chk(!ref_req, "R4 drain completes", int'(ref_req), 0);
    endtask

    initial begin
        int r0;
        int seed;
        bit allq;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cke, "R1 cke", int'(cke), 1);
        chk(cs_n && ras_n && cas_n && we_n, "R1 deselect", int'({cs_n, ras_n, cas_n, we_n}), 15);
        chk(!ap && !ref_req && !ref_urgent, "R1 ap/req/urgent", int'({ap, ref_req, ref_urgent}), 0);
        rst_n = 1'b1;

        // R2 / R3: interval timing, urgency, saturation
        do_reset();
        chk(!ref_req, "R1 req low after release", int'(ref_req), 0);
        repeat (N - 1) @(negedge clk);
        chk(!ref_req, "R2 req before first interval", int'(ref_req), 0);
        @(negedge clk);
        chk(ref_req, "R2 req at first interval", int'(ref_req), 1);
        repeat (7 * N - 1) @(negedge clk);
        chk(!ref_urgent, "R3 urgent one cycle early", int'(ref_urgent), 0);
        @(negedge clk);
        chk(ref_urgent, "R3 urgent at full backlog", int'(ref_urgent), 1);
        repeat (N) @(negedge clk);
        chk(ref_urgent && ref_req, "R3 urgent held, req high", int'({ref_urgent, ref_req}), 3);
        r0 = refs_seen;
        drain();
        chk(refs_seen - r0 == MAX_PEND, "R3 saturated backlog served", refs_seen - r0, MAX_PEND);

        // R5 / R6 / R7: precharge path, spacing, grant handling
        do_reset();
        repeat (N) @(negedge clk);
        allq = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!f_quiet()) allq = 1'b0;
        end
        chk(allq, "R7 no command without grant", int'(allq), 1);
        bank_open = 4'b0101;
        grant = 1'b1;
        @(negedge clk);
        chk(f_pre() && ap, "R5 precharge-all first", int'({f_pre(), ap}), 3);
        bank_open = '0;
        repeat (T_RP) @(negedge clk);
        chk(f_ref() && cke, "R5 refresh T_RP later", int'({f_ref(), cke}), 3);
        repeat (T_RFC - 1) @(negedge clk);
        chk(ref_req, "R6 busy through refresh cycle", int'(ref_req), 1);
        @(negedge clk);
        chk(!ref_req, "R6 release after refresh cycle", int'(ref_req), 0);
        allq = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (!f_quiet()) allq = 1'b0;
        end
        chk(allq, "R7 idle grant ignored", int'(allq), 1);
        grant = 1'b0;

        // R8..R11: self-refresh with a pending refresh
        do_reset();
        repeat (N) @(negedge clk);
        lp_req = 1'b1;
        #1;
        chk(ref_req, "R11 req with lp_req", int'(ref_req), 1);
        grant = 1'b1;
        @(negedge clk);
        chk(f_ref() && !cke, "R8 R11 entry pattern with cke low", int'({f_ref(), cke}), 2);
        grant = 1'b0;
        allq = 1'b1;
        repeat (N + 100) begin
            @(negedge clk);
            if (cke || !cs_n || !ref_req) allq = 1'b0;
        end
        chk(allq, "R9 held in self-refresh", int'(allq), 1);
        lp_req = 1'b0;
        @(negedge clk);
        chk(cke && f_quiet(), "R10 cke high, no command", int'({cke, f_quiet()}), 3);
        repeat (T_RFC - 1) @(negedge clk);
        chk(ref_req, "R10 busy after exit", int'(ref_req), 1);
        @(negedge clk);
        chk(!ref_req, "R8 R9 backlog cleared, timer held", int'(ref_req), 0);

        // R4: random grants and bank states, refresh count vs elapsed intervals
        do_reset();
        seed = $urandom(32'd4021);
        r0 = refs_seen;
        repeat (15000) begin
            @(negedge clk);
            if (f_pre()) bank_open = '0;
            grant = (($urandom % 4) == 0);
            if (!ref_req) bank_open = (($urandom % 3) == 0) ? NB'($urandom) : '0;
        end
        drain();
        chk(refs_seen - r0 == exp_refs(edges), "R4 refreshes equal intervals", refs_seen - r0, exp_refs(edges));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule